// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block holds the replacement ordering for a set-associative cache whose way count is a power of two (eight by default). Each set owns a binary tree of one bit per internal node, so a set with `WAYS` ways keeps `WAYS-1` bits. Every node names the half of its subtree that was used less recently. The block keeps and updates these bits and nothing else: tags and data live elsewhere.

The cache reports each hit or fill by raising `touch_en` for one cycle with the set and way that were used. On the next clock edge the nodes on the path from the root to that way are turned to face the other half. In the same cycle, and independently, the cache may query any set on `probe_set`. `victim_way` is combinational from the stored bits of that set. It is found by walking from the root to a leaf along the pointers. The touch input is a plain strobe that is accepted every cycle, so there is no back-pressure. A touch and a probe in the same cycle see the state from before that touch.

Top module: `plru_victim_sel`

## Requirements
- R1: After synchronous reset every tree bit is 0, so `victim_way` is 0 for every probed set.
- R2: A node bit of 0 selects the lower-numbered half and 1 selects the upper half. `victim_way` is made of the bits met on the walk, with the root bit as the most significant bit. Equivalently, at each split the victim lies in the half whose most recent touch is older. A half never touched counts as oldest, and when both halves are untouched the lower half is taken.
- R3: A touch updates the probed set's state on the next rising edge. From then on, `victim_way` for that set differs from the touched way until that set is touched again.
- R4: A touch to one set leaves the victim of every other set unchanged.
- R5: While `touch_en` is 0 the stored state holds, and the victim of a set being probed does not change.
- R6: In an 8-way set, starting from reset, touches to ways 0,5,4,7,3,2,1,6 in that order leave way 3 as the victim.
- R7: With `WAYS`=2 each set uses one bit, and the victim is always the way that was not touched last (exact LRU).
- R8: `victim_way` follows a change of `probe_set` in the same cycle, with no clock edge needed.
- R9: Touches to the same set on consecutive cycles are all applied, in order.
- R10: One touch changes at most log2(`WAYS`) bits of a set's tree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| touch_en | input | 1 | One-cycle strobe: a way of `touch_set` was used |
| touch_set | input | log2(SETS) | Set that was used |
| touch_way | input | log2(WAYS) | Way that was used |
| probe_set | input | log2(SETS) | Set whose victim is requested |
| victim_way | output | log2(WAYS) | Pseudo-LRU way of `probe_set` |

## Verification
The hold and avoidance properties look at one probed set. They assume `probe_set` stays the same across the cycle they check, and they say nothing when it moves. They also assume `touch_set` and `probe_set` name sets that exist. The stimulus changes all inputs only on the falling edge and draws set numbers from the valid range. It holds the probe still during the fixed ordering and isolation phases and lets it wander during the random phase, where the reference model checks each cycle instead.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // Direction encoded by one tree node.
  typedef enum logic {
    PT_LOWER = 1'b0,
    PT_UPPER = 1'b1
  } ptr_dir_e;

  // Bits needed to hold an index in [0, n-1], at least one.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/plru_tree_walk.sv
module plru_tree_walk
  import plru_pkg::*;
#(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:1]              tree,
  output logic [idx_bits(WAYS)-1:0]    way
);
  localparam int WW = idx_bits(WAYS);

  logic [WW-1:0] node;
  ptr_dir_e      dir;

  // Heap order: node 1 is the root, children of n are 2n and 2n+1.
  always_comb begin
    node = WW'(1);
    way  = '0;
    dir  = PT_LOWER;
    for (int lvl = 0; lvl < WW; lvl++) begin
      dir  = ptr_dir_e'(tree[node]);
      way  = (way << 1) | WW'(dir);
      node = (node << 1) | WW'(dir);
    end
  end
endmodule

// File: rtl/plru_tree_update.sv
module plru_tree_update
  import plru_pkg::*;
#(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:1]           cur_tree,
  input  logic [idx_bits(WAYS)-1:0] used_way,
  output logic [WAYS-1:1]           nxt_tree
);
  localparam int WW = idx_bits(WAYS);

  logic [WW-1:0] node;
  logic [WW-1:0] rest;
  ptr_dir_e      went;

  // Each node on the path is turned to face the half not just used.
  always_comb begin
    nxt_tree = cur_tree;
    node     = WW'(1);
    rest     = used_way;
    went     = PT_LOWER;
    for (int lvl = 0; lvl < WW; lvl++) begin
      went           = ptr_dir_e'(rest[WW-1]);
      nxt_tree[node] = (went == PT_LOWER) ? PT_UPPER : PT_LOWER;
      node           = (node << 1) | WW'(went);
      rest           = rest << 1;
    end
  end
endmodule

// File: rtl/plru_state_array.sv
module plru_state_array
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [idx_bits(SETS)-1:0] wr_set,
  input  logic [WAYS-1:1]           wr_tree,
  input  logic [idx_bits(SETS)-1:0] rd_a_set,
  output logic [WAYS-1:1]           rd_a_tree,
  input  logic [idx_bits(SETS)-1:0] rd_b_set,
  output logic [WAYS-1:1]           rd_b_tree
);
  localparam int SW = idx_bits(SETS);

  logic [WAYS-1:1] rows [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:1] row_q;
    always_ff @(posedge clk) begin
      if (rst)
        row_q <= '0;
      else if (wr_en && (wr_set == SW'(s)))
        row_q <= wr_tree;
    end
    assign rows[s] = row_q;
  end

  assign rd_a_tree = rows[rd_a_set];
  assign rd_b_tree = rows[rd_b_set];
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      touch_en,
  input  logic [idx_bits(SETS)-1:0] touch_set,
  input  logic [idx_bits(WAYS)-1:0] touch_way,
  input  logic [idx_bits(SETS)-1:0] probe_set,
  output logic [idx_bits(WAYS)-1:0] victim_way
);
  localparam int WW = idx_bits(WAYS);

  logic [WAYS-1:1] probe_tree;
  logic [WAYS-1:1] touch_tree;
  logic [WAYS-1:1] touch_next;

  plru_state_array #(.WAYS(WAYS), .SETS(SETS)) u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (touch_en),
    .wr_set    (touch_set),
    .wr_tree   (touch_next),
    .rd_a_set  (probe_set),
    .rd_a_tree (probe_tree),
    .rd_b_set  (touch_set),
    .rd_b_tree (touch_tree)
  );

  plru_tree_update #(.WAYS(WAYS)) u_update (
    .cur_tree (touch_tree),
    .used_way (touch_way),
    .nxt_tree (touch_next)
  );

  // R10
  path_bits_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |-> ($countones(touch_tree ^ touch_next) <= WW));

  plru_tree_walk #(.WAYS(WAYS)) u_walk (
    .tree (probe_tree),
    .way  (victim_way)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (victim_way == '0));

  // R3
  avoid_touched_chk: assert property (@(posedge clk) disable iff (rst)
    (touch_en && (touch_set == probe_set)) |=>
      ($stable(probe_set) -> (victim_way != $past(touch_way))));

  // R5
  hold_victim_chk: assert property (@(posedge clk) disable iff (rst)
    !(touch_en && (touch_set == probe_set)) |=>
      ($stable(probe_set) -> $stable(victim_way)));
endmodule

// File: tb/plru_victim_sel_test.sv
module plru_victim_sel_test;
  localparam int WAYS = 8;
  localparam int SETS = 16;
  localparam int WW   = 3;
  localparam int SW   = 4;
  localparam int SETS2 = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          touch_en  = 1'b0;
  logic [SW-1:0] touch_set = '0;
  logic [WW-1:0] touch_way = '0;
  logic [SW-1:0] probe_set = '0;
  logic [WW-1:0] victim_way;

  logic       b_en   = 1'b0;
  logic [1:0] b_set  = '0;
  logic       b_way  = 1'b0;
  logic [1:0] b_probe = '0;
  logic       b_victim;

  plru_victim_sel #(.WAYS(WAYS), .SETS(SETS)) uut (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_set(touch_set),
    .touch_way(touch_way), .probe_set(probe_set), .victim_way(victim_way)
  );

  plru_victim_sel #(.WAYS(2), .SETS(SETS2)) uut2 (
    .clk(clk), .rst(rst), .touch_en(b_en), .touch_set(b_set),
    .touch_way(b_way), .probe_set(b_probe), .victim_way(b_victim)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int stamp [SETS][WAYS];
  int tick  = 0;
  int last2 [SETS2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural model: victim lies in the half whose newest touch is older.
  function automatic int model_victim(input int s);
    int lo = 0;
    int size = WAYS;
    while (size > 1) begin
      int half = size / 2;
      int ml = -1;
      int mu = -1;
      for (int i = 0; i < half; i++) begin
        if (stamp[s][lo+i] > ml) ml = stamp[s][lo+i];
        if (stamp[s][lo+half+i] > mu) mu = stamp[s][lo+half+i];
      end
      if (mu < ml) lo = lo + half;
      size = half;
    end
    return lo;
  endfunction

  task automatic step(input bit v, input int s, input int w, input int q, input string req);
    @(negedge clk);
    touch_en  = v;
    touch_set = SW'(s);
    touch_way = WW'(w);
    probe_set = SW'(q);
    #1;
    chk(int'(victim_way) == model_victim(q), req, int'(victim_way), model_victim(q));
    @(posedge clk);
    if (v) begin
      stamp[s][w] = tick;
      tick++;
    end
  endtask

  task automatic step2(input bit v, input int s, input int w, input int q);
    @(negedge clk);
    b_en    = v;
    b_set   = 2'(s);
    b_way   = 1'(w);
    b_probe = 2'(q);
    #1;
    // R7: victim is the way not touched last
    chk(int'(b_victim) == 1 - last2[q], "R7", int'(b_victim), 1 - last2[q]);
    @(posedge clk);
    if (v) last2[s] = w;
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) stamp[s][w] = -1;
    for (int s = 0; s < SETS2; s++) last2[s] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 and R8: every set reads way 0, probe moving each cycle
    for (int s = 0; s < SETS; s++) step(0, 0, 0, s, "R1 R8");

    // R6: fixed ordering in set 5
    begin
      int seq [8] = '{0, 5, 4, 7, 3, 2, 1, 6};
      for (int i = 0; i < 8; i++) step(1, 5, seq[i], 5, "R3 R9");
    end
    step(0, 0, 0, 5, "R6");
    chk(victim_way == 3'd3, "R6", int'(victim_way), 3);

    // R4: touches to other sets leave set 5 alone
    for (int i = 0; i < 12; i++) step(1, (i % 4) + 8, i % WAYS, 5, "R4");
    chk(victim_way == 3'd3, "R4", int'(victim_way), 3);

    // R9: back-to-back touches to one set
    for (int w = WAYS - 1; w >= 0; w--) step(1, 2, w, 2, "R9");
    step(0, 0, 0, 2, "R9");

    // R2 R3: random touches and probes
    for (int i = 0; i < 600; i++) begin
      int ts = $urandom_range(SETS - 1, 0);
      int tw = $urandom_range(WAYS - 1, 0);
      int ps = (i % 3 == 0) ? ts : $urandom_range(SETS - 1, 0);
      step($urandom_range(3, 0) != 0, ts, tw, ps, "R2 R3");
    end

    // R5: idle cycles, probe still
    for (int i = 0; i < 10; i++) step(0, i % SETS, i % WAYS, 5, "R5");

    @(negedge clk);
    touch_en = 1'b0;

    // R7: two-way instance
    for (int s = 0; s < SETS2; s++) step2(0, 0, 0, s);
    for (int i = 0; i < 60; i++) begin
      int s = $urandom_range(SETS2 - 1, 0);
      step2($urandom_range(1, 0) == 1, s, $urandom_range(1, 0),
            (i % 2 == 0) ? s : $urandom_range(SETS2 - 1, 0));
    end

    @(negedge clk);
    b_en = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule